// File: doc/BRIEF.md
# Minimum-Count Synchronization Arbiter

This block decides, without depending on timing, which thread may perform a synchronization or atomic operation while all threads are running in parallel. Each thread presents its retired-instruction count, an active flag, a request flag and a completion flag. Only the active thread with the smallest count is eligible. If that thread is not requesting, nobody is granted, and every other requester waits.

Equal minimum counts are resolved in favour of the lowest thread index. Inactive or finished threads take no part in the comparison. The minimum is found by a combinational compare tree, and the grant decision is registered, so a grant is visible one cycle after the inputs that cause it.

A grant is one-hot and stays in place until the granted thread pulses completion. Synchronization operations are therefore strictly serialized, and each one finishes before the next grant is issued. The operation itself and the memory side are outside this block.

Top module: `min_count_sync_arbiter`

## Requirements
- R1: While rst_ni is low, and on the first cycle after reset, gnt_o is all zero and gnt_valid_o is 0.
- R2: When no grant is held, the block considers the winner: the active thread with the smallest count. If that winner has its req_i bit set, then after the next rising clock edge gnt_o has exactly that thread's bit set and gnt_valid_o is 1. Bit i of every per-thread vector belongs to thread i, and thread i's count is cnt_i[i*CNT_W +: CNT_W], compared as unsigned.
- R3: When several active threads share the smallest count, the winner is the one with the lowest index.
- R4: A requesting thread whose count is not the active minimum is not granted, even if it is the only requester. The block grants no thread while the minimum-count thread is not requesting.
- R5: Threads with active_i low are excluded from the minimum, whatever their count.
- R6: At most one gnt_o bit is set at any time, and gnt_valid_o is 1 exactly when a gnt_o bit is set.
- R7: While a grant is held, gnt_o does not change until the granted thread raises its done_i bit. Changes to counts, to requests and to the done_i bits of other threads have no effect on it.
- R8: A done_i pulse from the granted thread clears gnt_o and gnt_valid_o after the next edge. No new grant is issued on that same edge, so the next grant comes at the earliest one edge later.
- R9: With no active thread, no grant is issued, whatever the requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_i | input | N_THREADS*CNT_W | Packed per-thread retired-instruction counts |
| active_i | input | N_THREADS | Thread takes part in the minimum comparison |
| req_i | input | N_THREADS | Thread requests a synchronization operation |
| done_i | input | N_THREADS | Granted thread signals that its operation has completed |
| gnt_o | output | N_THREADS | One-hot grant |
| gnt_valid_o | output | 1 | A grant is held |

## Verification
A cycle-level reference model computes the expected grant on every clock. It is run against four kinds of input pattern:

- Distinct counts, with the requester at the minimum. This shows a correct comparison and the one-cycle latency.
- A lone requester that is not at the minimum. This separates grant-by-count from grant-by-request.
- Tied minimum counts. This exposes tie-breaking towards the wrong index.
- Low counts on inactive threads, or no active thread at all. This shows whether the active mask is applied before the comparison.

The hold and release sequences drive done from other threads and change counts during a grant. This catches a grant that moves or drops early, and a re-grant on the release edge.

// File: rtl/sync_arb_pkg.sv
package sync_arb_pkg;
  typedef enum logic {
    ARB_IDLE = 1'b0,
    ARB_HOLD = 1'b1
  } arb_state_e;
endpackage

// File: rtl/min_cnt_tree.sv
module min_cnt_tree #(
  parameter int N_THREADS = 4,
  parameter int CNT_W     = 16,
  parameter int ID_W      = (N_THREADS > 1) ? $clog2(N_THREADS) : 1
) (
  input  logic [N_THREADS*CNT_W-1:0] cnt_i,
  input  logic [N_THREADS-1:0]       active_i,
  output logic                       min_vld_o,
  output logic [ID_W-1:0]            min_id_o
);
  localparam int LVLS  = $clog2(N_THREADS);
  localparam int LEAFS = 1 << LVLS;
  localparam int NODES = 2 * LEAFS - 1;

  // heap layout: node 1 is root, leaves at LEAFS+i
  logic             nd_vld [1:NODES];
  logic [CNT_W-1:0] nd_cnt [1:NODES];
  logic [ID_W-1:0]  nd_id  [1:NODES];

  for (genvar i = 0; i < LEAFS; i++) begin : g_leaf
    if (i < N_THREADS) begin : g_real
      assign nd_vld[LEAFS+i] = active_i[i];
      assign nd_cnt[LEAFS+i] = cnt_i[i*CNT_W +: CNT_W];
      assign nd_id[LEAFS+i]  = ID_W'(i);
    end else begin : g_pad
      assign nd_vld[LEAFS+i] = 1'b0;
      assign nd_cnt[LEAFS+i] = '0;
      assign nd_id[LEAFS+i]  = '0;
    end
  end

  for (genvar k = 1; k < LEAFS; k++) begin : g_node
    logic take_lo;
    // lower-index side wins ties
    assign take_lo   = nd_vld[2*k] && (!nd_vld[2*k+1] || (nd_cnt[2*k] <= nd_cnt[2*k+1]));
    assign nd_vld[k] = nd_vld[2*k] || nd_vld[2*k+1];
    assign nd_cnt[k] = take_lo ? nd_cnt[2*k] : nd_cnt[2*k+1];
    assign nd_id[k]  = take_lo ? nd_id[2*k]  : nd_id[2*k+1];
  end

  assign min_vld_o = nd_vld[1];
  assign min_id_o  = nd_id[1];

  always_comb begin
    if (min_vld_o) begin
      // R5
      win_active_chk: assert (active_i[min_id_o]);
      for (int i = 0; i < N_THREADS; i++) begin
        if (active_i[i]) begin
          // R2
          win_is_min_chk: assert (nd_cnt[1] <= cnt_i[i*CNT_W +: CNT_W]);
        end
      end
    end
  end
endmodule

// File: rtl/sync_grant_ctrl.sv
module sync_grant_ctrl
  import sync_arb_pkg::*;
#(
  parameter int N_THREADS = 4,
  parameter int ID_W      = (N_THREADS > 1) ? $clog2(N_THREADS) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 win_vld_i,
  input  logic [ID_W-1:0]      win_id_i,
  input  logic [N_THREADS-1:0] req_i,
  input  logic [N_THREADS-1:0] done_i,
  output logic [N_THREADS-1:0] gnt_o,
  output logic                 gnt_valid_o
);
  arb_state_e           st_q;
  logic [N_THREADS-1:0] gnt_q;
  logic [N_THREADS-1:0] win_oh;
  logic                 grant_now;
  logic                 release_now;

  assign win_oh      = N_THREADS'(1) << win_id_i;
  assign grant_now   = (st_q == ARB_IDLE) && win_vld_i && |(req_i & win_oh);
  assign release_now = (st_q == ARB_HOLD) && |(done_i & gnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ARB_IDLE;
      gnt_q <= '0;
    end else if (grant_now) begin
      st_q  <= ARB_HOLD;
      gnt_q <= win_oh;
    end else if (release_now) begin
      st_q  <= ARB_IDLE;
      gnt_q <= '0;
    end
  end

  assign gnt_o       = gnt_q;
  assign gnt_valid_o = (st_q == ARB_HOLD);

  // R6
  gnt_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));
  // R6
  gnt_valid_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_valid_o == (gnt_o != '0));
  // R7
  gnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_valid_o && !(|(done_i & gnt_o))) |=> ($stable(gnt_o) && gnt_valid_o));
  // R8
  gnt_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_valid_o && |(done_i & gnt_o)) |=> !gnt_valid_o);
  // R2
  gnt_to_requester_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gnt_valid_o) |-> |($past(req_i) & gnt_o));
endmodule

// File: rtl/min_count_sync_arbiter.sv
module min_count_sync_arbiter #(
  parameter int N_THREADS = 4,
  parameter int CNT_W     = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [N_THREADS*CNT_W-1:0] cnt_i,
  input  logic [N_THREADS-1:0]       active_i,
  input  logic [N_THREADS-1:0]       req_i,
  input  logic [N_THREADS-1:0]       done_i,
  output logic [N_THREADS-1:0]       gnt_o,
  output logic                       gnt_valid_o
);
  localparam int ID_W = (N_THREADS > 1) ? $clog2(N_THREADS) : 1;

  logic            min_vld;
  logic [ID_W-1:0] min_id;

  min_cnt_tree #(
    .N_THREADS(N_THREADS),
    .CNT_W    (CNT_W),
    .ID_W     (ID_W)
  ) u_tree (
    .cnt_i    (cnt_i),
    .active_i (active_i),
    .min_vld_o(min_vld),
    .min_id_o (min_id)
  );

  sync_grant_ctrl #(
    .N_THREADS(N_THREADS),
    .ID_W     (ID_W)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .win_vld_i  (min_vld),
    .win_id_i   (min_id),
    .req_i      (req_i),
    .done_i     (done_i),
    .gnt_o      (gnt_o),
    .gnt_valid_o(gnt_valid_o)
  );

  // R4
  gnt_only_min_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gnt_valid_o) |-> ($past(min_vld) && (gnt_o == (N_THREADS'(1) << $past(min_id)))));
  // R9
  no_active_no_gnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!gnt_valid_o && active_i == '0) |=> !gnt_valid_o);
endmodule

// File: tb/min_count_sync_arbiter_bench.sv
module min_count_sync_arbiter_bench;
  localparam int N = 4;
  localparam int W = 16;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [N*W-1:0] cnt = '0;
  logic [N-1:0]   act = '0;
  logic [N-1:0]   req = '0;
  logic [N-1:0]   done = '0;
  logic [N-1:0]   gnt;
  logic           gv;

  int total = 0;
  int bad   = 0;
  int exp_g = -1;

  always #5 clk = ~clk;

  min_count_sync_arbiter #(.N_THREADS(N), .CNT_W(W)) u_min_count_sync_arbiter (
    .clk_i(clk), .rst_ni(rst_n), .cnt_i(cnt), .active_i(act),
    .req_i(req), .done_i(done), .gnt_o(gnt), .gnt_valid_o(gv)
  );

  task automatic set_cnts(input int c0, input int c1, input int c2, input int c3);
    cnt = {W'(c3), W'(c2), W'(c1), W'(c0)};
  endtask

  task automatic compare(input string tag);
    logic [N-1:0] e;
    e = (exp_g >= 0) ? (N'(1) << exp_g) : '0;
    total++;
    if (gnt !== e || gv !== (exp_g >= 0)) begin
      bad++;
      $display("FAIL %s: gnt=%b valid=%b expected gnt=%b valid=%b", tag, gnt, gv, e, exp_g >= 0);
    end
    total++;
    if ($countones(gnt) > 1) begin
      bad++;
      $display("FAIL R6: gnt=%b expected at most one bit", gnt);
    end
  endtask

  // reference model: next grant from current inputs, then compare after the edge
  task automatic step(input string tag);
    int nxt;
    int best;
    nxt = exp_g;
    if (exp_g >= 0) begin
      if (done[exp_g]) nxt = -1;
    end else begin
      best = -1;
      for (int i = 0; i < N; i++)
        if (act[i] && (best < 0 || cnt[i*W +: W] < cnt[best*W +: W])) best = i;
      if (best >= 0 && req[best]) nxt = best;
    end
    @(posedge clk);
    #1;
    exp_g = nxt;
    compare(tag);
  endtask

  initial begin
    #1_000_000;
    total++;
    bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    #1;
    compare("R1");
    rst_n = 1'b1;
    step("R1");

    // R2: requester at the minimum
    act = 4'b1111;
    set_cnts(10, 20, 30, 40);
    req = 4'b0001;
    step("R2");
    step("R2");
    done = 4'b0001;
    step("R8");
    done = '0;
    req  = '0;
    step("R8");

    // R4: lone requester not at minimum waits
    set_cnts(50, 20, 30, 40);
    req = 4'b0001;
    for (int k = 0; k < 3; k++) step("R4");
    set_cnts(50, 60, 70, 80);
    step("R4");
    done = 4'b0001;
    req  = '0;
    step("R8");
    done = '0;
    step("R8");

    // R3: tie on minimum goes to lowest index
    set_cnts(5, 3, 3, 9);
    req = 4'b0110;
    step("R3");
    // R7: hold against foreign done, count and request changes
    done = 4'b0100;
    step("R7");
    done = '0;
    set_cnts(100, 100, 100, 0);
    step("R7");
    req = 4'b1111;
    step("R7");
    // R8: release and re-grant only on a later edge
    done = 4'b0010;
    req  = 4'b1111;
    step("R8");
    done = '0;
    step("R8");
    done = 4'b1000;
    step("R8");
    done = '0;
    req  = 4'b0100;
    set_cnts(5, 100, 3, 9);
    step("R3");
    done = 4'b0100;
    req  = '0;
    step("R8");
    done = '0;

    // R5: inactive low count excluded
    act = 4'b1110;
    set_cnts(1, 50, 40, 30);
    req = 4'b1000;
    step("R5");
    step("R5");
    done = 4'b1000;
    req  = '0;
    step("R5");
    done = '0;
    act  = 4'b1111;
    req  = 4'b1000;
    step("R5");
    step("R5");

    // R9: no active thread
    act = '0;
    req = 4'b1111;
    for (int k = 0; k < 3; k++) step("R9");
    act = 4'b0010;
    req = 4'b0010;
    step("R9");
    done = 4'b0010;
    req  = '0;
    step("R9");
    done = '0;
    step("R9");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule